// File: doc/BRIEF.md
# Per-Lane Toggle-Bit Completion Poller

This block works out when a program or erase operation has finished on up to four byte-wide flash devices. The devices share one 32-bit data bus, and each device owns one byte lane of that bus. After a start, the poller asks the bus engine for read cycles at address 0, one at a time. For each lane it watches the toggle bit, bit 6 of the lane's byte. While a device is busy, this bit flips on every read. When the bit stops changing between two reads in a row, the device has finished. Each lane keeps its own completion flag. A lane that was not selected at start counts as finished from the outset.

The read request leaves the block as a valid/ready stream, and the read data comes back as a second valid/ready stream. The request carries no payload: every request means a read of address 0. The bus engine may hold `rd_req_ready` low for as long as it needs. The poller then keeps `rd_req_valid` high, and keeps it high until the request is taken. The poller has at most one read outstanding at a time. It raises `rd_rsp_ready` only while it is waiting for that read's data, so back-pressure on the response side never arises. A run ends in one of two ways: every lane is finished, or a set number of comparison reads has gone by. Either way the block emits a one-cycle done strobe. The lane flags and the timeout flag then hold their values until the next start.

Top module: `lane_toggle_poller`

## Requirements
- R1: While reset is applied and just after it is released, `rd_req_valid`, `rd_rsp_ready`, `done_pulse`, `timeout` and `lane_done` are all 0.
- R2: A start seen while the block is idle does three things one cycle later: it loads `lane_done` with the inverse of `lane_sel`, it clears `timeout`, and it raises `rd_req_valid`. Lane i is data bits [8i+7:8i] and is selected by `lane_sel[i]`. A start seen while a run is in progress is ignored.
- R3: The first read of a run only records the sample. No lane can become done on it, and it does not count toward the timeout.
- R4: On each later read, a pending lane i becomes done when data bit 8i+6 equals the same bit of the previous read. The previous sample is replaced after every read. No other data bit has any effect.
- R5: Once a lane is done, it stays done until the next accepted start, whatever its toggle bit does later.
- R6: A run issues exactly one priming read plus one read per comparison, and stops once all four flags are set. `done_pulse` rises in the cycle after the response that completes the run.
- R7: If MAX_POLLS comparison reads pass without all lanes done, the run stops. `timeout` and `done_pulse` rise together, and `lane_done` shows the lanes still pending as 0.
- R8: `rd_req_valid` stays high until `rd_req_ready` is seen. `rd_rsp_ready` is high only while a read is outstanding, never at the same time as `rd_req_valid`. A response offered at any other time is ignored.
- R9: `done_pulse` lasts exactly one cycle. `lane_done` and `timeout` keep their values until the next accepted start.
- R10: With `lane_sel` = 0, the run still makes its priming read, then ends with `lane_done` = 4'b1111 and `timeout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a completion wait (taken only when idle) |
| lane_sel | input | 4 | Lanes to wait on; bit i selects data byte i |
| rd_req_valid | output | 1 | Read request for address 0 |
| rd_req_ready | input | 1 | Bus engine accepts the read request |
| rd_rsp_valid | input | 1 | Read data is present |
| rd_rsp_ready | output | 1 | Poller can take read data |
| rd_rsp_data | input | 32 | Read data word |
| done_pulse | output | 1 | One-cycle end-of-run strobe |
| lane_done | output | 4 | Per-lane completion flags |
| timeout | output | 1 | Run ended on the comparison-read limit |

## Verification
The read data comes from per-lane patterns of four kinds. In the first kind, each lane's bit toggles for a different number of reads and then freezes; this tests whether each lane finishes on its own schedule rather than with the others. In the second kind, the toggle bit starts at 0, so a design that compared the priming read against a cleared register would stop early; this tests the priming read. The third kind adds noise on the non-toggle bits, which exposes any decode of the wrong bit position. The fourth kind lets a lane freeze and then toggle again, which tests whether its done flag stays set. Further runs cover the following: unselected lanes that never settle; a lane that never settles, which forces the timeout; an empty selection; a start issued mid-run; and a stray response offered while idle. Every run also counts the read requests the poller issues and compares that count against the expected number of priming and comparison reads.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } tpoll_state_e;
endpackage

// File: rtl/tpoll_lane.sv
// One byte lane: previous toggle-bit sample plus a sticky done flag.
module tpoll_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic init,       // accepted start
  input  logic init_done,  // lane not selected -> done from the outset
  input  logic prime_cap,  // priming read arrives
  input  logic cmp_cap,    // comparison read arrives
  input  logic tog,        // this lane's toggle bit of the current read
  output logic done_q,
  output logic done_nxt    // value done_q takes if this read is a comparison
);
  logic last_q;

  assign done_nxt = done_q | (tog == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      last_q <= 1'b0;
    end else if (init) begin
      done_q <= init_done;
    end else if (prime_cap) begin
      last_q <= tog;
    end else if (cmp_cap) begin
      done_q <= done_nxt;
      last_q <= tog;
    end
  end
endmodule

// File: rtl/tpoll_ctrl.sv
// Sequencer: priming read, comparison reads, poll limit, end strobe.
module tpoll_ctrl
  import tpoll_pkg::*;
#(
  parameter int MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic all_done_q,
  input  logic all_done_nxt,
  output logic rd_req_valid,
  input  logic rd_req_ready,
  input  logic rd_rsp_valid,
  output logic rd_rsp_ready,
  output logic init,
  output logic prime_cap,
  output logic cmp_cap,
  output logic done_pulse,
  output logic timeout
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(MAX_POLLS - 1);

  tpoll_state_e     state_q;
  logic             prime_q;
  logic [CNT_W-1:0] poll_cnt_q;
  logic             rsp_fire;
  logic             finish_all;
  logic             hit_limit;

  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_rsp_ready = (state_q == ST_WAIT);
  assign init         = (state_q == ST_IDLE) && start;
  assign rsp_fire     = rd_rsp_ready && rd_rsp_valid;
  assign prime_cap    = rsp_fire && prime_q;
  assign cmp_cap      = rsp_fire && !prime_q;
  assign finish_all   = prime_q ? all_done_q : all_done_nxt;
  assign hit_limit    = cmp_cap && (poll_cnt_q == LAST_POLL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      prime_q    <= 1'b0;
      poll_cnt_q <= '0;
      done_pulse <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q    <= ST_REQ;
            prime_q    <= 1'b1;
            poll_cnt_q <= '0;
            timeout    <= 1'b0;
          end
        end
        ST_REQ: begin
          if (rd_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            prime_q <= 1'b0;
            if (cmp_cap) poll_cnt_q <= poll_cnt_q + 1'b1;
            if (finish_all) begin
              state_q    <= ST_IDLE;
              done_pulse <= 1'b1;
            end else if (hit_limit) begin
              state_q    <= ST_IDLE;
              done_pulse <= 1'b1;
              timeout    <= 1'b1;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_toggle_poller.sv
module lane_toggle_poller #(
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int TOG_POS   = 6,
  parameter int MAX_POLLS = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LANES-1:0]        lane_sel,
  output logic                    rd_req_valid,
  input  logic                    rd_req_ready,
  input  logic                    rd_rsp_valid,
  output logic                    rd_rsp_ready,
  input  logic [LANES*LANE_W-1:0] rd_rsp_data,
  output logic                    done_pulse,
  output logic [LANES-1:0]        lane_done,
  output logic                    timeout
);
  localparam int DATA_W = LANES * LANE_W;

  logic             init, prime_cap, cmp_cap;
  logic [LANES-1:0] done_nxt;
  logic             unused_data_bits;

  // Only the toggle bit of each lane is decoded.
  assign unused_data_bits = ^rd_rsp_data[DATA_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tpoll_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (init),
      .init_done (~lane_sel[g]),
      .prime_cap (prime_cap),
      .cmp_cap   (cmp_cap),
      .tog       (rd_rsp_data[g*LANE_W + TOG_POS]),
      .done_q    (lane_done[g]),
      .done_nxt  (done_nxt[g])
    );
  end

  tpoll_ctrl #(.MAX_POLLS(MAX_POLLS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .all_done_q   (&lane_done),
    .all_done_nxt (&done_nxt),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .init         (init),
    .prime_cap    (prime_cap),
    .cmp_cap      (cmp_cap),
    .done_pulse   (done_pulse),
    .timeout      (timeout)
  );
endmodule

// File: rtl/tpoll_checker.sv
module tpoll_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic             rd_rsp_ready,
  input logic             done_pulse,
  input logic             timeout,
  input logic [LANES-1:0] lane_done
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid); // R8

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((lane_done & $past(lane_done)) == $past(lane_done))); // R5

  AST_TIMEOUT_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done_pulse); // R7

  AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!rd_req_valid && !rd_rsp_ready)); // R6
endmodule

bind lane_toggle_poller tpoll_checker #(.LANES(LANES)) u_tpoll_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_rsp_ready (rd_rsp_ready),
  .done_pulse   (done_pulse),
  .timeout      (timeout),
  .lane_done    (lane_done)
);

// File: tb/lane_toggle_poller_tb_top.sv
`timescale 1ns/1ps
module lane_toggle_poller_tb_top;
  localparam int LANES = 4, LANE_W = 8, TOG_POS = 6, MAX_POLLS = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] lane_sel = '0;
  logic rd_req_valid, rd_rsp_ready, done_pulse, timeout;
  logic rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic [3:0] lane_done;

  always #2.5 clk = ~clk;

  lane_toggle_poller #(.LANES(LANES), .LANE_W(LANE_W), .TOG_POS(TOG_POS),
                       .MAX_POLLS(MAX_POLLS)) dut_i (.*);

  typedef struct { logic [3:0] done; logic to; int reads; int id; } exp_t;
  exp_t        sbq[$];
  logic [31:0] words[$];
  int checks = 0, fails = 0, nreq = 0, case_no = 0;
  bit stall_en = 1'b0, summary_done = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  endtask

  // mode 0: toggle for t reads then freeze; mode 1: freeze on reads 0..1 then toggle forever
  function automatic logic [31:0] mk_word(int i, int t[4], int mode[4], logic [3:0] base, bit noise);
    logic [31:0] w;
    int k;
    w = noise ? (32'(i) * 32'h9E3779B1 + 32'h1234567) : 32'h0;
    for (int l = 0; l < 4; l++) begin
      if (mode[l] == 0) k = (i < t[l]) ? i : t[l];
      else              k = (i <= 1) ? 0 : i - 1;
      w[l*8 + 6] = k[0] ^ base[l];
    end
    return w;
  endfunction

  // Expected outcome from the requirements, applied to the queued read words.
  function automatic exp_t model(logic [3:0] sel);
    exp_t e;
    logic [31:0] last;
    int cnt = 0;
    e.done = ~sel; e.to = 1'b0; e.reads = 1; e.id = 0;
    last = words[0];
    if (&e.done) return e;
    for (int i = 1; i < words.size(); i++) begin
      e.reads++; cnt++;
      for (int l = 0; l < 4; l++)
        if (!e.done[l] && words[i][l*8+6] == last[l*8+6]) e.done[l] = 1'b1;
      last = words[i];
      if (&e.done) break;
      if (cnt == MAX_POLLS) begin e.to = 1'b1; break; end
    end
    return e;
  endfunction

  // Bus responder: handshakes are decided at negedge, take effect at the next posedge.
  initial begin
    bit req_armed = 0, rsp_armed = 0, pending = 0, tog = 0;
    int lat = 0;
    forever begin
      @(negedge clk);
      if (req_armed) begin req_armed = 0; nreq++; pending = 1; lat = nreq % 3; end
      if (rsp_armed) begin rsp_armed = 0; rd_rsp_valid = 1'b0; pending = 0; end
      rd_req_ready = 1'b0;
      if (pending && !rd_rsp_valid) begin
        if (lat == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = (words.size() > 0) ? words.pop_front() : 32'h0;
        end else lat--;
      end
      if (pending && rd_rsp_valid && rd_rsp_ready) rsp_armed = 1;
      if (rd_req_valid && !pending) begin
        tog = ~tog;
        if (!stall_en || tog) begin rd_req_ready = 1'b1; req_armed = 1; end
      end
    end
  end

  // Monitor: pops one expectation per end strobe.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (done_pulse) begin
        if (sbq.size() == 0) chk(1'b0, "R6", "unexpected done_pulse", 32'd1, 32'd0);
        else begin
          e = sbq.pop_front();
          chk(lane_done == e.done, "R4/R7", $sformatf("case %0d lane_done", e.id), 32'(lane_done), 32'(e.done));
          chk(timeout == e.to, "R7", $sformatf("case %0d timeout", e.id), 32'(timeout), 32'(e.to));
          chk(nreq == e.reads, "R6/R3", $sformatf("case %0d read count", e.id), 32'(nreq), 32'(e.reads));
        end
      end
    end
  end

  task automatic run_case(logic [3:0] sel, int t[4], int mode[4], logic [3:0] base,
                          bit noise, bit inject);
    exp_t e;
    case_no++;
    words.delete();
    for (int i = 0; i < MAX_POLLS + 3; i++) words.push_back(mk_word(i, t, mode, base, noise));
    e = model(sel);
    e.id = case_no;
    @(negedge clk);
    nreq = 0;
    sbq.push_back(e);
    start = 1'b1; lane_sel = sel;
    @(negedge clk);
    start = 1'b0;
    chk(lane_done == ~sel, "R2", $sformatf("case %0d init flags", case_no), 32'(lane_done), 32'(~sel));
    chk(timeout == 1'b0, "R2", "timeout cleared", 32'(timeout), 32'd0);
    if (inject) begin
      repeat (3) @(negedge clk);
      start = 1'b1; lane_sel = ~sel;      // R2: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    wait (sbq.size() == 0);
    @(negedge clk);
    chk(done_pulse == 1'b0, "R9", "pulse width", 32'(done_pulse), 32'd0);
    repeat (4) @(negedge clk);
    chk(lane_done == e.done, "R9", "flags held", 32'(lane_done), 32'(e.done));
    chk(timeout == e.to, "R9", "timeout held", 32'(timeout), 32'(e.to));
    chk(rd_req_valid == 1'b0, "R6", "no request after end", 32'(rd_req_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run hung", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [3:0] held;
    repeat (3) @(negedge clk);
    chk(rd_req_valid == 1'b0, "R1", "req in reset", 32'(rd_req_valid), 32'd0);
    chk(lane_done == 4'b0, "R1", "flags in reset", 32'(lane_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_pulse == 1'b0 && timeout == 1'b0, "R1", "pulse/timeout after reset",
        32'({done_pulse, timeout}), 32'd0);
    chk(rd_rsp_ready == 1'b0, "R1", "rsp_ready after reset", 32'(rd_rsp_ready), 32'd0);

    // R4/R3: staggered settle points, toggle bit starting at 0
    run_case(4'hF, '{1, 3, 2, 5}, '{0, 0, 0, 0}, 4'h0, 1'b0, 1'b0);
    // R4: already stable, noise on other bits
    stall_en = 1'b1;
    run_case(4'hF, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 4'hF, 1'b1, 1'b0);
    // R2: unselected lanes never settle but are done from the start
    run_case(4'h5, '{2, 99, 1, 99}, '{0, 0, 0, 0}, 4'h3, 1'b1, 1'b0);
    // R7: lane 2 never settles; start injected mid-run (R2)
    run_case(4'hF, '{1, 2, 99, 3}, '{0, 0, 0, 0}, 4'h0, 1'b0, 1'b1);
    // R10: empty selection
    stall_en = 1'b0;
    run_case(4'h0, '{99, 99, 99, 99}, '{0, 0, 0, 0}, 4'h0, 1'b1, 1'b0);
    // R5: lane 0 settles early then toggles again while lane 1 is still pending
    run_case(4'h3, '{0, 6, 0, 0}, '{1, 0, 0, 0}, 4'h0, 1'b0, 1'b0);
    // R4: noise, mixed selection
    run_case(4'hA, '{99, 4, 99, 1}, '{0, 0, 0, 0}, 4'h5, 1'b1, 1'b0);

    // R8: stray response while idle is ignored
    held = lane_done;
    rd_rsp_data = 32'hFFFF_FFFF;
    rd_rsp_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_rsp_ready == 1'b0, "R8", "rsp_ready while idle", 32'(rd_rsp_ready), 32'd0);
    rd_rsp_valid = 1'b0;
    @(negedge clk);
    chk(lane_done == held, "R8", "flags after stray response", 32'(lane_done), 32'(held));
    chk(done_pulse == 1'b0, "R8", "no strobe from stray response", 32'(done_pulse), 32'd0);
    summary();
  end
endmodule